// File: doc/BRIEF.md
# Step Attenuator Programming Controller

This block sits on the host side of a 5-bit RF step attenuator and turns a
single command into the pin activity that loads a new attenuation setting. A
command carries a level in half-dB units and a delivery choice. The delivery
choice is either a bit-serial load through a data/clock/latch trio or a latched
parallel load through five weighted data lines. Commands are taken through a
valid/ready handshake. Ready stays low while a load is in progress, and also
until a minimum interval has passed since the previous latch pulse. A command
that is presented during that time is held off and is never lost.

Every pin is driven from a flop. Each timing minimum of the attenuator's
interface is a parameter counted in system-clock cycles. The defaults assume a
100 MHz clock, with nanosecond limits rounded up. The serial word is the level
moved up one bit position (four times the dB value), sent least significant bit
first. The two bits above the level and the lowest bit of the word are always
zero.

Top module: `atten_prog`

## Requirements
- R1: The serial word for level L is 2*L. Bit 0 of the word carries no level information. Bits 1..5 hold L, with bit 1 weighted 0.5 dB. Bits 6 and 7 are zero. As an example, level 25 (12.5 dB) gives binary 00110010.
- R2: A requested level above 31 is clamped to 31 (15.5 dB), in both delivery modes.
- R3: A serial load produces exactly 8 rising edges on `ser_clk` before `latch_en` rises. Bits go out least significant first, so word bit 0 is sent first and word bit 7 last. `latch_en` is low whenever `ser_clk` is high.
- R4: Every high phase and every low phase of `ser_clk` lasts at least CLK_HALF cycles.
- R5: `ser_data` is stable for at least SI_SETUP cycles before each rising `ser_clk` edge. It also stays stable for at least SI_HOLD cycles after that edge.
- R6: In a serial load, `latch_en` rises at least LE_SETUP cycles after the last rising `ser_clk` edge. In every load, `latch_en` stays high for at least LE_WIDTH cycles.
- R7: A parallel load drives `par_bits` with the clamped level and produces no `ser_clk` pulse. Bit 0 is the 0.5 dB line and bit 4 is the 8 dB line. `par_bits` is stable for at least PAR_SETUP cycles before `latch_en` rises and for at least PAR_HOLD cycles after it falls.
- R8: Whenever `mode_sel` is 1 (serial), `par_bits` is all zero.
- R9: `mode_sel` is 1 for serial loads and 0 for parallel loads. It has the same PAR_SETUP / PAR_HOLD window around the latch pulse as the parallel lines.
- R10: Consecutive rising edges of `latch_en` are at least UPDATE_GAP cycles apart.
- R11: `cmd_ready` falls in the cycle after a command is accepted. A command held valid while `cmd_ready` is low is accepted later, and loads are delivered in command order.
- R12: After reset, `cmd_ready` is 1, `mode_sel` is 1, and `ser_data`, `ser_clk`, `latch_en` and `par_bits` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_level | input | IN_W | Requested level in half-dB units (clamped to 31) |
| cmd_serial | input | 1 | 1 = serial load, 0 = latched parallel load |
| ser_data | output | 1 | Serial data to attenuator |
| ser_clk | output | 1 | Serial shift clock to attenuator |
| latch_en | output | 1 | Latch pulse to attenuator |
| mode_sel | output | 1 | Interface select: 1 serial, 0 parallel |
| par_bits | output | 5 | Weighted parallel control lines |

## Verification
All pins change just after a rising clock edge and are read at the falling edge, so every interval is counted in whole cycles from those samples. Ready must be low at the first falling edge after acceptance. The latch pulse of a parallel load is due PAR_SETUP cycles after acceptance. For a serial load it is due PAR_SETUP + 8*(max(CLK_HALF,SI_SETUP)+max(CLK_HALF,SI_HOLD)) + LE_SETUP cycles after acceptance, and ready returns only after the hold phase has ended and UPDATE_GAP cycles have passed since that pulse. The bench does not wait for fixed delays. It measures each high, low, setup, hold and gap interval at the edge where it ends and compares the count with its minimum. The delivered word is rebuilt from the pins at each latch pulse and popped against the scoreboard queue filled at acceptance.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

  localparam int LEVEL_W = 5;
  localparam int WORD_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_LE_WAIT,
    ST_LE_HI,
    ST_HOLD
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Word = 4 * dB = 2 * half-dB level; top two bits and bit 0 stay zero.
  function automatic logic [WORD_W-1:0] build_word(input logic [LEVEL_W-1:0] level);
    return {2'b00, level, 1'b0};
  endfunction

endpackage

// File: rtl/atten_word_fmt.sv
module atten_word_fmt
  import atten_prog_pkg::*;
#(
  parameter int IN_W = 6
) (
  input  logic [IN_W-1:0]    raw_level,
  output logic [LEVEL_W-1:0] level,
  output logic [WORD_W-1:0]  word
);

  generate
    if (IN_W > LEVEL_W) begin : g_clamp
      localparam logic [IN_W-1:0] MAX_RAW = IN_W'((1 << LEVEL_W) - 1);
      always_comb begin
        if (raw_level > MAX_RAW) level = '1;
        else                     level = raw_level[LEVEL_W-1:0];
      end
    end else begin : g_extend
      always_comb level = LEVEL_W'(raw_level);
    end
  endgenerate

  always_comb word = build_word(level);

endmodule

// File: rtl/atten_gap_timer.sv
module atten_gap_timer #(
  parameter int GAP = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic done
);

  localparam int GW = $clog2(GAP + 1);
  localparam logic [GW-1:0] GAP_V = GW'(GAP);

  logic [GW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (kick)             remain_q <= GAP_V;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign done = (remain_q == '0);

endmodule

// File: rtl/atten_phase_seq.sv
module atten_phase_seq
  import atten_prog_pkg::*;
#(
  parameter int T_LO      = 3,
  parameter int T_HI      = 3,
  parameter int LE_SETUP  = 1,
  parameter int LE_WIDTH  = 3,
  parameter int PAR_SETUP = 10,
  parameter int PAR_HOLD  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_serial,
  input  logic [WORD_W-1:0]  start_word,
  input  logic [LEVEL_W-1:0] start_level,
  output logic               idle,
  output logic               le_rise,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               latch_en,
  output logic               mode_sel,
  output logic [LEVEL_W-1:0] par_bits
);

  localparam int MAXLEN = max2(max2(max2(T_LO, T_HI), max2(LE_SETUP, LE_WIDTH)),
                               max2(PAR_SETUP, PAR_HOLD));
  localparam int CW = $clog2(MAXLEN + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [CW-1:0] L_LO  = CW'(T_LO - 1);
  localparam logic [CW-1:0] L_HI  = CW'(T_HI - 1);
  localparam logic [CW-1:0] L_LES = CW'(LE_SETUP - 1);
  localparam logic [CW-1:0] L_LEW = CW'(LE_WIDTH - 1);
  localparam logic [CW-1:0] L_PS  = CW'(PAR_SETUP - 1);
  localparam logic [CW-1:0] L_PH  = CW'(PAR_HOLD - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  seq_state_t        state_q, nxt_state;
  logic [CW-1:0]     cnt_q, nxt_cnt;
  logic [BW-1:0]     bit_q, nxt_bit;
  logic              serial_q;
  logic [WORD_W-1:0] word_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    nxt_bit   = bit_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          nxt_state = ST_SETUP;
          nxt_cnt   = L_PS;
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          if (serial_q) begin
            nxt_state = ST_BIT_LO;
            nxt_cnt   = L_LO;
            nxt_bit   = '0;
          end else begin
            nxt_state = ST_LE_HI;
            nxt_cnt   = L_LEW;
          end
        end
      end
      ST_BIT_LO: begin
        if (cnt_zero) begin
          nxt_state = ST_BIT_HI;
          nxt_cnt   = L_HI;
        end
      end
      ST_BIT_HI: begin
        if (cnt_zero) begin
          if (bit_q == LAST_BIT) begin
            nxt_state = ST_LE_WAIT;
            nxt_cnt   = L_LES;
          end else begin
            nxt_state = ST_BIT_LO;
            nxt_cnt   = L_LO;
            nxt_bit   = bit_q + 1'b1;
          end
        end
      end
      ST_LE_WAIT: begin
        if (cnt_zero) begin
          nxt_state = ST_LE_HI;
          nxt_cnt   = L_LEW;
        end
      end
      ST_LE_HI: begin
        if (cnt_zero) begin
          nxt_state = ST_HOLD;
          nxt_cnt   = L_PH;
        end
      end
      ST_HOLD: begin
        if (cnt_zero) nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  // Pins are registered from the next-state decode so they never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      serial_q <= 1'b1;
      word_q   <= '0;
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
      latch_en <= 1'b0;
      mode_sel <= 1'b1;
      par_bits <= '0;
    end else begin
      state_q  <= nxt_state;
      cnt_q    <= nxt_cnt;
      bit_q    <= nxt_bit;
      if (start && state_q == ST_IDLE) begin
        serial_q <= start_serial;
        word_q   <= start_word;
        mode_sel <= start_serial;
        par_bits <= start_serial ? '0 : start_level;
      end
      ser_clk  <= (nxt_state == ST_BIT_HI);
      latch_en <= (nxt_state == ST_LE_HI);
      ser_data <= (nxt_state == ST_BIT_LO || nxt_state == ST_BIT_HI) ? word_q[nxt_bit] : 1'b0;
    end
  end

  assign idle    = (state_q == ST_IDLE);
  assign le_rise = (nxt_state == ST_LE_HI) && (state_q != ST_LE_HI);

endmodule

// File: rtl/atten_prog.sv
module atten_prog
  import atten_prog_pkg::*;
#(
  parameter int IN_W       = 6,
  parameter int CLK_HALF   = 3,
  parameter int SI_SETUP   = 1,
  parameter int SI_HOLD    = 1,
  parameter int LE_SETUP   = 1,
  parameter int LE_WIDTH   = 3,
  parameter int PAR_SETUP  = 10,
  parameter int PAR_HOLD   = 10,
  parameter int UPDATE_GAP = 4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [IN_W-1:0]    cmd_level,
  input  logic               cmd_serial,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               latch_en,
  output logic               mode_sel,
  output logic [LEVEL_W-1:0] par_bits
);

  localparam int T_LO = max2(CLK_HALF, SI_SETUP);
  localparam int T_HI = max2(CLK_HALF, SI_HOLD);

  logic               accept;
  logic               seq_idle;
  logic               gap_done;
  logic               le_rise_evt;
  logic [LEVEL_W-1:0] fmt_level;
  logic [WORD_W-1:0]  fmt_word;

  assign cmd_ready = seq_idle && gap_done;
  assign accept    = cmd_valid && cmd_ready;

  atten_word_fmt #(.IN_W(IN_W)) u_fmt (
    .raw_level (cmd_level),
    .level     (fmt_level),
    .word      (fmt_word)
  );

  atten_phase_seq #(
    .T_LO      (T_LO),
    .T_HI      (T_HI),
    .LE_SETUP  (LE_SETUP),
    .LE_WIDTH  (LE_WIDTH),
    .PAR_SETUP (PAR_SETUP),
    .PAR_HOLD  (PAR_HOLD)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .start_serial (cmd_serial),
    .start_word   (fmt_word),
    .start_level  (fmt_level),
    .idle         (seq_idle),
    .le_rise      (le_rise_evt),
    .ser_data     (ser_data),
    .ser_clk      (ser_clk),
    .latch_en     (latch_en),
    .mode_sel     (mode_sel),
    .par_bits     (par_bits)
  );

  atten_gap_timer #(.GAP(UPDATE_GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (le_rise_evt),
    .done  (gap_done)
  );

endmodule

// File: rtl/atten_prog_chk.sv
module atten_prog_chk #(
  parameter int CLK_HALF   = 3,
  parameter int LE_WIDTH   = 3,
  parameter int UPDATE_GAP = 4000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       cmd_ready,
  input logic       ser_data,
  input logic       ser_clk,
  input logic       latch_en,
  input logic       mode_sel,
  input logic [4:0] par_bits
);

  localparam int HW = $clog2(CLK_HALF + 2);
  localparam int WW = $clog2(LE_WIDTH + 2);
  localparam int GW = $clog2(UPDATE_GAP + 2);
  localparam logic [HW-1:0] HALF_V = HW'(CLK_HALF);
  localparam logic [WW-1:0] LEW_V  = WW'(LE_WIDTH);
  localparam logic [GW-1:0] GAP_V  = GW'(UPDATE_GAP);

  logic [HW-1:0] hi_run;
  logic [WW-1:0] le_run;
  logic [GW-1:0] gap_since;
  logic          le_d;
  logic          seen_le;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      le_run    <= '0;
      gap_since <= '0;
      le_d      <= 1'b0;
      seen_le   <= 1'b0;
    end else begin
      le_d   <= latch_en;
      hi_run <= !ser_clk ? '0 : (hi_run == HALF_V ? hi_run : hi_run + 1'b1);
      le_run <= !latch_en ? '0 : (le_run == LEW_V ? le_run : le_run + 1'b1);
      if (latch_en && !le_d) begin
        gap_since <= GW'(1);
        seen_le   <= 1'b1;
      end else if (gap_since != GAP_V) begin
        gap_since <= gap_since + 1'b1;
      end
    end
  end

  p_shift_le_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !latch_en);

  p_clk_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_run >= HALF_V);

  p_si_rise_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  p_si_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  p_le_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |-> le_run >= LEW_V);

  p_par_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> $stable(par_bits));

  p_serial_par_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |-> par_bits == 5'd0);

  p_mode_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> $stable(mode_sel));

  p_update_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latch_en) && seen_le) |-> gap_since >= GAP_V);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);

endmodule

bind atten_prog atten_prog_chk #(
  .CLK_HALF   (CLK_HALF),
  .LE_WIDTH   (LE_WIDTH),
  .UPDATE_GAP (UPDATE_GAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .cmd_ready (cmd_ready),
  .ser_data  (ser_data),
  .ser_clk   (ser_clk),
  .latch_en  (latch_en),
  .mode_sel  (mode_sel),
  .par_bits  (par_bits)
);

// File: tb/atten_prog_bench.sv
module atten_prog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W       = 6;
  localparam int CLK_HALF   = 3;
  localparam int SI_SETUP   = 1;
  localparam int SI_HOLD    = 1;
  localparam int LE_SETUP   = 1;
  localparam int LE_WIDTH   = 3;
  localparam int PAR_SETUP  = 10;
  localparam int PAR_HOLD   = 10;
  localparam int UPDATE_GAP = 300;
  localparam int WATCHDOG   = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [IN_W-1:0] cmd_level = '0;
  logic            cmd_serial = 1'b0;
  logic            ser_data, ser_clk, latch_en, mode_sel;
  logic [4:0]      par_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  atten_prog #(
    .IN_W(IN_W), .CLK_HALF(CLK_HALF), .SI_SETUP(SI_SETUP), .SI_HOLD(SI_HOLD),
    .LE_SETUP(LE_SETUP), .LE_WIDTH(LE_WIDTH), .PAR_SETUP(PAR_SETUP),
    .PAR_HOLD(PAR_HOLD), .UPDATE_GAP(UPDATE_GAP)
  ) u_atten_prog (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_level(cmd_level), .cmd_serial(cmd_serial), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_en(latch_en), .mode_sel(mode_sel), .par_bits(par_bits)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    n_sent = 0;
  int    n_got = 0;
  int    cyc = 0;
  bit    finished = 0;
  bit    mon_on = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: holds the command until taken, then pushes the expected load.
  task automatic send(input int level, input bit serial, input string req);
    int lv;
    logic [7:0] w;
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_level  = IN_W'(level);
    cmd_serial = serial;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    lv = (level > 31) ? 31 : level;
    w  = 8'(lv * 2);
    exp_q.push_back({serial, w});
    tag_q.push_back(req);
    n_sent++;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R11", "ready low after accept", int'(cmd_ready), 0);
  endtask

  // Monitor state
  logic p_clk, p_data, p_le, p_mode;
  logic [4:0] p_par;
  int data_age, rise_age, hi_run, lo_run, le_run, fall_age, par_age, le_gap, bits_n;
  bit have_le;
  logic [7:0] sh;

  always @(negedge clk) begin
    if (rst_n && mon_on && !finished) begin
      automatic bit rise  = ser_clk && !p_clk;
      automatic bit fall  = !ser_clk && p_clk;
      automatic bit le_r  = latch_en && !p_le;
      automatic bit le_f  = !latch_en && p_le;
      automatic bit d_chg = (ser_data != p_data);
      automatic bit p_chg = (par_bits != p_par) || (mode_sel != p_mode);
      data_age = d_chg ? 1 : data_age + 1;
      par_age  = p_chg ? 1 : par_age + 1;
      le_gap++;
      if (rise) begin
        chk(data_age - 1 >= SI_SETUP, "R5", "data setup before clk rise", data_age - 1, SI_SETUP);
        chk(lo_run >= CLK_HALF, "R4", "clk low time", lo_run, CLK_HALF);
        chk(!latch_en, "R3", "latch low while shifting", int'(latch_en), 0);
        sh = {ser_data, sh[7:1]};
        bits_n++;
        rise_age = 0;
      end else begin
        rise_age++;
        if (d_chg)
          chk(rise_age >= SI_HOLD, "R5", "data hold after clk rise", rise_age, SI_HOLD);
      end
      if (fall) chk(hi_run >= CLK_HALF, "R4", "clk high time", hi_run, CLK_HALF);
      if (le_r) begin
        automatic logic [8:0] obs;
        automatic logic [8:0] exp;
        automatic string req;
        chk(par_age - 1 >= PAR_SETUP, "R9", "lines/mode setup before latch", par_age - 1, PAR_SETUP);
        if (have_le) chk(le_gap >= UPDATE_GAP, "R10", "latch spacing", le_gap, UPDATE_GAP);
        if (mode_sel) begin
          chk(rise_age >= LE_SETUP, "R6", "latch after last clk rise", rise_age, LE_SETUP);
          chk(bits_n == 8, "R3", "clk rises per serial load", bits_n, 8);
          chk(par_bits == 5'd0, "R8", "parallel lines in serial load", int'(par_bits), 0);
          obs = {1'b1, sh};
        end else begin
          chk(bits_n == 0, "R7", "clk rises in parallel load", bits_n, 0);
          obs = {1'b0, 2'b00, par_bits, 1'b0};
        end
        if (exp_q.size() == 0) begin
          chk(0, "R11", "unexpected load", int'(obs), -1);
        end else begin
          exp = exp_q.pop_front();
          req = tag_q.pop_front();
          chk(obs == exp, req, "delivered {mode,word}", int'(obs), int'(exp));
        end
        n_got++;
        have_le = 1;
        le_gap = 0;
        bits_n = 0;
      end
      if (le_f) begin
        chk(le_run >= LE_WIDTH, "R6", "latch pulse width", le_run, LE_WIDTH);
        fall_age = 0;
      end else begin
        fall_age++;
      end
      if (p_chg && !le_r) begin
        chk(!latch_en, "R7", "lines change during latch", int'(latch_en), 0);
        if (have_le) chk(fall_age >= PAR_HOLD, "R9", "lines/mode hold after latch", fall_age, PAR_HOLD);
      end
      hi_run = ser_clk ? hi_run + 1 : 0;
      lo_run = ser_clk ? 0 : lo_run + 1;
      le_run = latch_en ? le_run + 1 : 0;
    end
    p_clk = ser_clk; p_data = ser_data; p_le = latch_en;
    p_par = par_bits; p_mode = mode_sel;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !finished) begin
      chk(0, "R11", "watchdog expired", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    data_age = 1000; rise_age = 1000; hi_run = 0; lo_run = 1000; le_run = 0;
    fall_age = 1000; par_age = 1000; le_gap = 0; bits_n = 0; have_le = 0; sh = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(cmd_ready == 1'b1, "R12", "ready after reset", int'(cmd_ready), 1);
    chk(mode_sel == 1'b1, "R12", "mode after reset", int'(mode_sel), 1);
    chk(latch_en == 1'b0 && ser_clk == 1'b0 && ser_data == 1'b0, "R12", "serial pins after reset",
        int'({latch_en, ser_clk, ser_data}), 0);
    chk(par_bits == 5'd0, "R12", "parallel lines after reset", int'(par_bits), 0);
    mon_on = 1;

    send(25, 1'b1, "R1");   // 12.5 dB -> 00110010
    send(31, 1'b0, "R7");
    send(0,  1'b1, "R1");
    send(0,  1'b0, "R7");
    send(63, 1'b1, "R2");
    send(40, 1'b0, "R2");
    for (int i = 0; i < 5; i++) begin
      send(1 << i, 1'b1, "R3");
      send(1 << i, 1'b0, "R7");
    end
    send(21, 1'b1, "R1");
    send(10, 1'b1, "R1");
    send(32, 1'b1, "R2");
    send(17, 1'b0, "R9");
    send(14, 1'b1, "R9");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (UPDATE_GAP + 20) @(negedge clk);
    chk(n_got == n_sent, "R11", "loads delivered vs accepted", n_got, n_sent);
    chk(cmd_ready == 1'b1, "R11", "ready after gap", int'(cmd_ready), 1);
    finish_run();
  end

endmodule